// File: doc/BRIEF.md
# Modem Control and Status Register Pair with Loopback

This block holds the modem control byte and the modem status byte of a serial port. Four modem input lines (clear-to-send, data-set-ready, ring indicator, carrier detect) are sampled on every clock. Their present levels are kept in the upper half of the status byte. Change events are latched as sticky flags in the lower half until software reads the status byte. The ring indicator flag only marks the end of a ring, that is a high-to-low change. An any-change output feeds the modem-status interrupt source of the port.

The control byte drives the request-to-send and data-terminal-ready pins and two general outputs. It also holds a loopback switch. While loopback is on, the status byte shows the control outputs in place of the external lines. The request-to-send and data-terminal-ready pins are forced inactive, and the stored status is frozen. The input lines are assumed to be already synchronised to `clk`. Reset is synchronous and active high.

Top module: `modem_status_ctl`

## Requirements
- R1: While `rst` is high, the next edge sets `sts_q` to 0xB0 and `ctl_q` to 0x08. The same edge sets `rts_o`, `dtr_o`, `out1_o` and `any_delta_o` low and `out2_o` high.
- R2: A `ctl_wr` pulse stores `ctl_wdata[4:0]`, and `ctl_q` reads back {3'b000, stored bits}. The stored bits are bit 4 loopback, bit 3 OUT2, bit 2 OUT1, bit 1 RTS and bit 0 DTR.
- R3: With loopback off, the edge after a line is sampled shows its level in `sts_q`: bit 7 carrier detect, bit 6 ring, bit 5 data-set-ready, bit 4 clear-to-send.
- R4: With loopback off, any change of clear-to-send, data-set-ready or carrier detect, in either direction, sets `sts_q` bit 0, 1 or 3 respectively.
- R5: With loopback off, `sts_q` bit 2 is set by a 1-to-0 change of the ring line. A 0-to-1 change does not set it.
- R6: A `sts_rd` strobe with loopback off clears `sts_q[3:0]` at the next edge and leaves `sts_q[7:4]` unchanged. Without a strobe, set change bits stay set.
- R7: A line change sampled in the same cycle as a `sts_rd` strobe leaves its change bit set after the clear.
- R8: With loopback on, `sts_q` reads {OUT2, OUT1, DTR, RTS, 4'b0000} from the control bits as they stand after the same edge.
- R9: With loopback on, `rts_o` and `dtr_o` are low. Otherwise they follow control bits 1 and 0. `out1_o` and `out2_o` always follow control bits 2 and 3.
- R10: With loopback on, line activity and `sts_rd` strobes leave the stored status unchanged. After loopback is switched off, `sts_q` again shows the stored status, compared against the lines from that point on.
- R11: `any_delta_o` is high exactly when at least one stored change bit is set. It updates on the same edge as `sts_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_wr | input | 1 | Write strobe for the control byte |
| ctl_wdata | input | 8 | Control byte write data |
| ctl_q | output | 8 | Control byte read value |
| sts_rd | input | 1 | Status byte read strobe (clears change bits) |
| sts_q | output | 8 | Status byte read value |
| cts_i | input | 1 | Clear-to-send line |
| dsr_i | input | 1 | Data-set-ready line |
| ri_i | input | 1 | Ring indicator line |
| dcd_i | input | 1 | Carrier detect line |
| rts_o | output | 1 | Request-to-send output |
| dtr_o | output | 1 | Data-terminal-ready output |
| out1_o | output | 1 | General output 1 |
| out2_o | output | 1 | General output 2 |
| any_delta_o | output | 1 | High while any change bit is set |

## Verification
The bench builds the block with its default parameters. With these, the ring line is the only line whose change bit fires on the falling edge alone, and the reset levels are carrier detect, data-set-ready and clear-to-send high. That brings the asymmetric ring rule, the read-versus-change collision and the loopback freeze within reach of a short directed sequence. A behavioural model checks every output on every clock. Freezing in loopback is observed by leaving loopback and reading the status that reappears.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int NLINES = 4;
  localparam int STS_W  = 2 * NLINES;
  localparam int CTL_W  = 5;
  // control bit positions
  localparam int C_DTR  = 0;
  localparam int C_RTS  = 1;
  localparam int C_OUT1 = 2;
  localparam int C_OUT2 = 3;
  localparam int C_LOOP = 4;
  // line index inside a nibble: {dcd, ri, dsr, cts}
  localparam int L_CTS = 0;
  localparam int L_DSR = 1;
  localparam int L_RI  = 2;
  localparam int L_DCD = 3;

  function automatic logic [NLINES-1:0] loop_levels(input logic [CTL_W-1:0] c);
    logic [NLINES-1:0] v;
    v[L_DCD] = c[C_OUT2];
    v[L_RI]  = c[C_OUT1];
    v[L_DSR] = c[C_DTR];
    v[L_CTS] = c[C_RTS];
    return v;
  endfunction
endpackage

// File: rtl/mdm_ctl_reg.sv
module mdm_ctl_reg
  import mdm_pkg::*;
#(
  parameter logic [CTL_W-1:0] RST_VAL = 5'b01000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CTL_W-1:0] wdata,
  output logic [CTL_W-1:0] ctl_q,
  output logic [CTL_W-1:0] ctl_nxt,
  output logic             rts_o,
  output logic             dtr_o,
  output logic             out1_o,
  output logic             out2_o
);
  always_comb ctl_nxt = wr ? wdata : ctl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= RST_VAL;
      rts_o  <= RST_VAL[C_RTS] & ~RST_VAL[C_LOOP];
      dtr_o  <= RST_VAL[C_DTR] & ~RST_VAL[C_LOOP];
      out1_o <= RST_VAL[C_OUT1];
      out2_o <= RST_VAL[C_OUT2];
    end else begin
      ctl_q  <= ctl_nxt;
      rts_o  <= ctl_nxt[C_RTS] & ~ctl_nxt[C_LOOP];
      dtr_o  <= ctl_nxt[C_DTR] & ~ctl_nxt[C_LOOP];
      out1_o <= ctl_nxt[C_OUT1];
      out2_o <= ctl_nxt[C_OUT2];
    end
  end
endmodule

// File: rtl/mdm_line_track.sv
module mdm_line_track
  import mdm_pkg::*;
#(
  parameter logic [NLINES-1:0] FALL_ONLY = 4'b0100,
  parameter logic [NLINES-1:0] RST_LVL   = 4'b1011
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              clr,
  input  logic [NLINES-1:0] line_i,
  output logic [NLINES-1:0] lvl_nxt,
  output logic [NLINES-1:0] dlt_nxt
);
  for (genvar i = 0; i < NLINES; i++) begin : g_line
    logic lvl_q, dlt_q, chg;
    always_comb begin
      if (hold) begin
        chg        = 1'b0;
        lvl_nxt[i] = lvl_q;
        dlt_nxt[i] = dlt_q;
      end else begin
        if (FALL_ONLY[i]) chg = lvl_q & ~line_i[i];
        else              chg = lvl_q ^ line_i[i];
        lvl_nxt[i] = line_i[i];
        dlt_nxt[i] = (dlt_q & ~clr) | chg;
      end
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        lvl_q <= RST_LVL[i];
        dlt_q <= 1'b0;
      end else begin
        lvl_q <= lvl_nxt[i];
        dlt_q <= dlt_nxt[i];
      end
    end
  end
endmodule

// File: rtl/mdm_sts_view.sv
module mdm_sts_view
  import mdm_pkg::*;
#(
  parameter logic [NLINES-1:0] RST_LVL = 4'b1011
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loop_nxt,
  input  logic [CTL_W-1:0]  ctl_nxt,
  input  logic [NLINES-1:0] lvl_nxt,
  input  logic [NLINES-1:0] dlt_nxt,
  output logic [STS_W-1:0]  sts_q,
  output logic              any_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q <= {RST_LVL, {NLINES{1'b0}}};
      any_q <= 1'b0;
    end else begin
      sts_q <= loop_nxt ? {loop_levels(ctl_nxt), {NLINES{1'b0}}}
                        : {lvl_nxt, dlt_nxt};
      any_q <= |dlt_nxt;
    end
  end
endmodule

// File: rtl/modem_status_ctl.sv
module modem_status_ctl
  import mdm_pkg::*;
#(
  parameter logic [NLINES-1:0] FALL_ONLY = 4'b0100,
  parameter logic [NLINES-1:0] RST_LVL   = 4'b1011,
  parameter logic [CTL_W-1:0]  CTL_RST   = 5'b01000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_wdata,
  output logic [7:0] ctl_q,
  input  logic       sts_rd,
  output logic [7:0] sts_q,
  input  logic       cts_i,
  input  logic       dsr_i,
  input  logic       ri_i,
  input  logic       dcd_i,
  output logic       rts_o,
  output logic       dtr_o,
  output logic       out1_o,
  output logic       out2_o,
  output logic       any_delta_o
);
  logic [CTL_W-1:0]  ctl_r, ctl_n;
  logic [NLINES-1:0] lines, lvl_n, dlt_n;

  always_comb begin
    lines        = '0;
    lines[L_CTS] = cts_i;
    lines[L_DSR] = dsr_i;
    lines[L_RI]  = ri_i;
    lines[L_DCD] = dcd_i;
  end

  mdm_ctl_reg #(.RST_VAL(CTL_RST)) u_ctl (
    .clk(clk), .rst(rst), .wr(ctl_wr), .wdata(ctl_wdata[CTL_W-1:0]),
    .ctl_q(ctl_r), .ctl_nxt(ctl_n),
    .rts_o(rts_o), .dtr_o(dtr_o), .out1_o(out1_o), .out2_o(out2_o)
  );

  mdm_line_track #(.FALL_ONLY(FALL_ONLY), .RST_LVL(RST_LVL)) u_trk (
    .clk(clk), .rst(rst), .hold(ctl_r[C_LOOP]), .clr(sts_rd),
    .line_i(lines), .lvl_nxt(lvl_n), .dlt_nxt(dlt_n)
  );

  mdm_sts_view #(.RST_LVL(RST_LVL)) u_view (
    .clk(clk), .rst(rst), .loop_nxt(ctl_n[C_LOOP]), .ctl_nxt(ctl_n),
    .lvl_nxt(lvl_n), .dlt_nxt(dlt_n), .sts_q(sts_q), .any_q(any_delta_o)
  );

  assign ctl_q = {{(8-CTL_W){1'b0}}, ctl_r};
endmodule

// File: rtl/modem_status_ctl_chk.sv
module modem_status_ctl_chk (
  input logic       clk,
  input logic       rst,
  input logic       ctl_wr,
  input logic [7:0] ctl_wdata,
  input logic [7:0] ctl_q,
  input logic       sts_rd,
  input logic [7:0] sts_q,
  input logic       cts_i,
  input logic       dsr_i,
  input logic       ri_i,
  input logic       dcd_i,
  input logic       rts_o,
  input logic       dtr_o,
  input logic       any_delta_o
);
  assert_reset_vals_R1: assert property (@(posedge clk)
    rst |=> (sts_q == 8'hB0 && ctl_q == 8'h08 && !any_delta_o));

  assert_ctl_store_R2: assert property (@(posedge clk) disable iff (rst)
    ctl_wr |=> ctl_q[4:0] == $past(ctl_wdata[4:0]));

  assert_cts_delta_R4: assert property (@(posedge clk) disable iff (rst)
    (!ctl_q[4] && !ctl_wr && cts_i != sts_q[4]) |=> sts_q[0]);

  assert_ri_rise_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (!ctl_q[4] && !ctl_wr && !sts_q[2] && !sts_q[6] && ri_i) |=> (!sts_q[2] && sts_q[6]));

  assert_read_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (!ctl_q[4] && !ctl_wr && sts_rd && {dcd_i, ri_i, dsr_i, cts_i} == sts_q[7:4])
    |=> (sts_q[3:0] == 4'h0 && $stable(sts_q[7:4])));

  assert_loop_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    ctl_q[4] |-> (!rts_o && !dtr_o));

  assert_any_delta_R11: assert property (@(posedge clk) disable iff (rst)
    !ctl_q[4] |-> (any_delta_o == (|sts_q[3:0])));
endmodule

bind modem_status_ctl modem_status_ctl_chk u_chk (
  .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
  .sts_rd(sts_rd), .sts_q(sts_q), .cts_i(cts_i), .dsr_i(dsr_i), .ri_i(ri_i),
  .dcd_i(dcd_i), .rts_o(rts_o), .dtr_o(dtr_o), .any_delta_o(any_delta_o)
);

// File: tb/sim_modem_status_ctl.sv
module sim_modem_status_ctl;
  localparam int PERIOD = 10;

  logic clk = 0, rst = 1;
  logic ctl_wr = 0, sts_rd = 0;
  logic [7:0] ctl_wdata = 0;
  logic cts = 1, dsr = 1, ri = 0, dcd = 1;
  logic [7:0] ctl_q, sts_q;
  logic rts_o, dtr_o, out1_o, out2_o, any_o;

  int n_chk = 0, n_fail = 0;

  modem_status_ctl u0 (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
    .sts_rd(sts_rd), .sts_q(sts_q), .cts_i(cts), .dsr_i(dsr), .ri_i(ri), .dcd_i(dcd),
    .rts_o(rts_o), .dtr_o(dtr_o), .out1_o(out1_o), .out2_o(out2_o), .any_delta_o(any_o)
  );

  always #(PERIOD/2) clk = ~clk;

  // behavioural reference model
  logic [3:0] m_lvl, m_dlt;
  logic [4:0] m_ctl;
  logic [7:0] m_sts;
  logic m_rts, m_dtr, m_o1, m_o2, m_any;

  always @(posedge clk) begin
    logic [3:0] pins, ch;
    logic [4:0] nc;
    pins = {dcd, ri, dsr, cts};
    if (rst) begin
      m_lvl = 4'hB; m_dlt = 0; nc = 5'h08;
    end else begin
      nc = ctl_wr ? ctl_wdata[4:0] : m_ctl;
      if (!m_ctl[4]) begin
        ch = m_lvl ^ pins;
        ch[2] = m_lvl[2] && !pins[2];
        m_dlt = (sts_rd ? 4'h0 : m_dlt) | ch;
        m_lvl = pins;
      end
    end
    m_ctl = nc;
    m_sts = m_ctl[4] ? {m_ctl[3], m_ctl[2], m_ctl[0], m_ctl[1], 4'h0} : {m_lvl, m_dlt};
    m_rts = m_ctl[1] && !m_ctl[4];
    m_dtr = m_ctl[0] && !m_ctl[4];
    m_o1 = m_ctl[2];
    m_o2 = m_ctl[3];
    m_any = |m_dlt;
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    chk("R2 model ctl_q", ctl_q, {3'b0, m_ctl});
    chk(m_ctl[4] ? "R8 model sts_q" : "R4 model sts_q", sts_q, m_sts);
    chk("R9 model pins", {4'b0, rts_o, dtr_o, out1_o, out2_o}, {4'b0, m_rts, m_dtr, m_o1, m_o2});
    chk("R11 model any_delta", {7'b0, any_o}, {7'b0, m_any});
  endtask

  task automatic wr_ctl(logic [7:0] v);
    ctl_wr = 1; ctl_wdata = v; cyc(); ctl_wr = 0;
  endtask

  task automatic rd_sts();
    sts_rd = 1; cyc(); sts_rd = 0;
  endtask

  initial begin
    #(PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk); cyc(); cyc();
    rst = 0;
    chk("R1 sts", sts_q, 8'hB0);
    chk("R1 ctl", ctl_q, 8'h08);
    chk("R1 pins", {rts_o, dtr_o, out1_o, out2_o, any_o}, 5'b00010);
    cyc();
    wr_ctl(8'hE3);
    chk("R2 ctl keeps 4:0", ctl_q, 8'h03);
    chk("R9 rts/dtr follow", {rts_o, dtr_o}, 2'b11);
    cts = 0; cyc();
    chk("R3 R4 cts fall", sts_q, 8'hA1);
    chk("R11 any set", any_o, 1);
    cyc();
    chk("R6 sticky", sts_q, 8'hA1);
    rd_sts();
    chk("R6 read clear", sts_q, 8'hA0);
    ri = 1; cyc();
    chk("R5 ri rise no delta", sts_q, 8'hE0);
    ri = 0; cyc();
    chk("R5 ri fall delta", sts_q, 8'hA4);
    rd_sts();
    dsr = 0; sts_rd = 1; cyc(); sts_rd = 0;
    chk("R7 change during read", sts_q, 8'h82);
    rd_sts();
    dcd = 0; cyc();
    chk("R4 dcd fall", sts_q, 8'h08);
    dcd = 1; dsr = 1; cts = 1; cyc();
    chk("R4 rises", sts_q, 8'hBB);
    rd_sts();
    chk("R6 clear all", sts_q, 8'hB0);
    chk("R11 any clear", any_o, 0);
    wr_ctl(8'h1A);
    chk("R8 loop view a", sts_q, 8'h90);
    chk("R9 loop pins", {rts_o, dtr_o, out2_o}, 3'b001);
    wr_ctl(8'h15);
    chk("R8 loop view b", sts_q, 8'h60);
    cts = 0; cyc(); cts = 1; rd_sts();
    wr_ctl(8'h08);
    chk("R10 frozen clean", sts_q, 8'hB0);
    cts = 0; cyc();
    wr_ctl(8'h18);
    ri = 1; rd_sts(); ri = 0; cyc();
    wr_ctl(8'h08);
    chk("R10 frozen delta kept", sts_q, 8'hA1);
    chk("R11 any after loop", any_o, 1);
    rd_sts(); cyc();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule